// File: doc/BRIEF.md
# Masked Scalar Half-to-Single Widening Unit

This datapath unit takes the lowest 16-bit half-precision element of a second source and widens it exactly into a 32-bit single-precision value. It places the result in lane 0 of a vector destination, under control of a one-bit predicate. Bits 127:32 of the destination always come from a separate 128-bit first source. Every bit from 128 up to the top of the parameterizable vector width is cleared.

When the predicate is disabled, or its bit is set, lane 0 receives the converted value. When the predicate bit is clear, lane 0 becomes zero in zeroing mode, or keeps the supplied old lane-0 value in merging mode. Two exception indications come out as one-cycle pulses: invalid (a signalling NaN) and denormal (a subnormal input). They are raised only when lane 0 is actually computed, and a suppress control can silence both.

The unit has one register stage. A request strobed with `in_valid` appears on the outputs, together with `out_valid`, after the next rising clock edge.

Top module: `hcvt_lane0_unit`

## Requirements
- R1: A normal half input (exponent field 1..30) produces a single value with the same sign, the exponent field plus 112, and the 10 fraction bits placed in single fraction bits 22:13, with the low 13 bits zero.
- R2: A half zero gives a single zero of the same sign. A half infinity (exponent 31, fraction 0) gives exponent 0xFF and fraction 0 with the same sign.
- R3: A half subnormal input (exponent 0, fraction nonzero) with leading one at fraction bit p gives single exponent field 103+p. The fraction bits below p, left-aligned, form the single fraction. The denormal pulse is raised.
- R4: A half NaN (exponent 31, fraction nonzero) gives single exponent 0xFF, single fraction bit 22 set and half fraction bits 8:0 in single bits 21:13. The invalid pulse is raised only when half fraction bit 9 is clear (a signalling NaN).
- R5: Destination bits 127:32 equal bits 127:32 of the first source for every request, whatever the predicate.
- R6: Destination bits from 128 to VEC_W-1 are always zero.
- R7: With `pred_en` low, or `pred_bit` high, lane 0 (bits 31:0) receives the converted value.
- R8: With `pred_en` high, `pred_bit` low and `zero_mode` high, lane 0 is 0x00000000.
- R9: With `pred_en` high, `pred_bit` low and `zero_mode` low, lane 0 equals `old_lane0`.
- R10: With `quiet_exc` high, neither `flag_invalid` nor `flag_denorm` is raised.
- R11: The flags are raised only for a request whose lane 0 is computed, and only in the cycle in which `out_valid` is high.
- R12: `out_valid` is high exactly one cycle after each cycle with `in_valid` high. The destination holds its value while no request arrives.
- R13: An asynchronous active-low reset clears the destination, `out_valid` and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| src_a | input | 128 | First source; bits 127:32 pass to the destination |
| src_b | input | 16 | Half-precision value to widen |
| old_lane0 | input | 32 | Current lane-0 content, kept in merging mode |
| pred_bit | input | 1 | Predicate bit for lane 0 |
| pred_en | input | 1 | High when predication applies |
| zero_mode | input | 1 | High selects zeroing, low selects merging |
| quiet_exc | input | 1 | High suppresses both exception pulses |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| dst | output | VEC_W | Registered destination vector |
| flag_invalid | output | 1 | Pulse: signalling NaN converted |
| flag_denorm | output | 1 | Pulse: subnormal input converted |

## Verification
Exception reporting and predicate masking act in the same cycle. An input that would raise a flag can arrive with its lane masked off or with suppression requested, and the mask decides both the lane content and whether a pulse may appear. The bench sends signalling NaNs and subnormals with the predicate clear in both zeroing and merging mode, and with suppression set while the lane is live. The scoreboard compares the lane-0 word and both flag pulses of each result together against an expectation built from the requirements.

// File: rtl/hcvt_pkg.sv
package hcvt_pkg;

  localparam int HALF_W      = 16;
  localparam int HALF_EXP_W  = 5;
  localparam int HALF_FRAC_W = 10;
  localparam int HALF_BIAS   = 15;

  localparam int SGL_W       = 32;
  localparam int SGL_EXP_W   = 8;
  localparam int SGL_FRAC_W  = 23;
  localparam int SGL_BIAS    = 127;

  localparam int FRAC_PAD    = SGL_FRAC_W - HALF_FRAC_W;
  localparam int EXP_REBIAS  = SGL_BIAS - HALF_BIAS;

  localparam int LANE_W      = SGL_W;
  localparam int BASE_W      = 128;

  typedef enum logic [2:0] {
    HC_ZERO,
    HC_SUB,
    HC_NORM,
    HC_INF,
    HC_QNAN,
    HC_SNAN
  } hclass_e;

  typedef struct packed {
    logic [SGL_W-1:0] value;
    logic             invalid;
    logic             denorm;
  } widen_res_t;

endpackage

// File: rtl/hcvt_lzc.sv
module hcvt_lzc #(
  parameter int W  = 10,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count,
  output logic          none
);

  always_comb begin
    count = '0;
    none  = 1'b1;
    for (int i = W - 1; i >= 0; i--) begin
      if (none && vec[i]) begin
        count = CW'(W - 1 - i);
        none  = 1'b0;
      end
    end
  end

endmodule

// File: rtl/hcvt_widen.sv
module hcvt_widen
  import hcvt_pkg::*;
(
  input  logic [HALF_W-1:0] half_in,
  output widen_res_t        res
);

  localparam int LZ_W = $clog2(HALF_FRAC_W + 1);
  localparam logic [SGL_EXP_W-1:0] REBIAS_E = SGL_EXP_W'(EXP_REBIAS);

  logic                   h_sign;
  logic [HALF_EXP_W-1:0]  h_exp;
  logic [HALF_FRAC_W-1:0] h_frac;
  logic [LZ_W-1:0]        lz;
  logic                   frac_zero;
  logic [HALF_FRAC_W-1:0] sub_frac;
  logic [SGL_EXP_W-1:0]   sub_exp;
  hclass_e                cls;

  assign h_sign = half_in[HALF_W-1];
  assign h_exp  = half_in[HALF_W-2 -: HALF_EXP_W];
  assign h_frac = half_in[HALF_FRAC_W-1:0];

  hcvt_lzc #(.W(HALF_FRAC_W)) lzc_i (
    .vec   (h_frac),
    .count (lz),
    .none  (frac_zero)
  );

  // Subnormal normalization: drop the leading one, pull the exponent down.
  assign sub_frac = h_frac << (lz + 1'b1);
  assign sub_exp  = REBIAS_E - SGL_EXP_W'(lz);

  always_comb begin
    if (h_exp == '0) begin
      cls = frac_zero ? HC_ZERO : HC_SUB;
    end else if (h_exp == '1) begin
      if (frac_zero)                     cls = HC_INF;
      else if (h_frac[HALF_FRAC_W-1])    cls = HC_QNAN;
      else                               cls = HC_SNAN;
    end else begin
      cls = HC_NORM;
    end
  end

  always_comb begin
    res = '0;
    res.value[SGL_W-1] = h_sign;
    unique case (cls)
      HC_ZERO: ;
      HC_SUB: begin
        res.value[SGL_W-2 -: SGL_EXP_W] = sub_exp;
        res.value[SGL_FRAC_W-1:0]       = {sub_frac, {FRAC_PAD{1'b0}}};
        res.denorm                      = 1'b1;
      end
      HC_NORM: begin
        res.value[SGL_W-2 -: SGL_EXP_W] = SGL_EXP_W'(h_exp) + REBIAS_E;
        res.value[SGL_FRAC_W-1:0]       = {h_frac, {FRAC_PAD{1'b0}}};
      end
      HC_INF: begin
        res.value[SGL_W-2 -: SGL_EXP_W] = '1;
      end
      HC_QNAN, HC_SNAN: begin
        res.value[SGL_W-2 -: SGL_EXP_W] = '1;
        res.value[SGL_FRAC_W-1:0]       = {1'b1, h_frac[HALF_FRAC_W-2:0], {FRAC_PAD{1'b0}}};
        res.invalid                     = (cls == HC_SNAN);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/hcvt_lane_sel.sv
module hcvt_lane_sel
  import hcvt_pkg::*;
(
  input  logic [LANE_W-1:0] conv_val,
  input  logic [LANE_W-1:0] keep_val,
  input  logic              pred_en,
  input  logic              pred_bit,
  input  logic              zero_mode,
  output logic [LANE_W-1:0] lane_val,
  output logic              lane_live
);

  assign lane_live = ~pred_en | pred_bit;

  always_comb begin
    if (lane_live)      lane_val = conv_val;
    else if (zero_mode) lane_val = '0;
    else                lane_val = keep_val;
  end

endmodule

// File: rtl/hcvt_lane0_unit.sv
module hcvt_lane0_unit
  import hcvt_pkg::*;
#(
  parameter int VEC_W = 512
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [BASE_W-1:0]    src_a,
  input  logic [HALF_W-1:0]    src_b,
  input  logic [LANE_W-1:0]    old_lane0,
  input  logic                 pred_bit,
  input  logic                 pred_en,
  input  logic                 zero_mode,
  input  logic                 quiet_exc,
  output logic                 out_valid,
  output logic [VEC_W-1:0]     dst,
  output logic                 flag_invalid,
  output logic                 flag_denorm
);

  widen_res_t          wres;
  logic [LANE_W-1:0]   lane_val;
  logic                lane_live;
  logic                unused_src_lo;

  logic [VEC_W-1:0]    dst_d, dst_q;
  logic                vld_d, vld_q;
  logic                inv_d, inv_q;
  logic                den_d, den_q;
  logic                load_en;
  logic                flag_ok;

  assign unused_src_lo = ^src_a[LANE_W-1:0];

  hcvt_widen widen_i (
    .half_in (src_b),
    .res     (wres)
  );

  hcvt_lane_sel sel_i (
    .conv_val  (wres.value),
    .keep_val  (old_lane0),
    .pred_en   (pred_en),
    .pred_bit  (pred_bit),
    .zero_mode (zero_mode),
    .lane_val  (lane_val),
    .lane_live (lane_live)
  );

  // Next-state logic.
  always_comb begin
    load_en = in_valid;
    flag_ok = in_valid & lane_live & ~quiet_exc;
    vld_d   = in_valid;
    inv_d   = flag_ok & wres.invalid;
    den_d   = flag_ok & wres.denorm;
    dst_d   = dst_q;
    if (load_en) begin
      dst_d                      = '0;
      dst_d[BASE_W-1:LANE_W]     = src_a[BASE_W-1:LANE_W];
      dst_d[LANE_W-1:0]          = lane_val;
    end
  end

  // Register stage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q <= '0;
      vld_q <= 1'b0;
      inv_q <= 1'b0;
      den_q <= 1'b0;
    end else begin
      dst_q <= dst_d;
      vld_q <= vld_d;
      inv_q <= inv_d;
      den_q <= den_d;
    end
  end

  assign dst          = dst_q;
  assign out_valid    = vld_q;
  assign flag_invalid = inv_q;
  assign flag_denorm  = den_q;

endmodule

// File: rtl/hcvt_lane0_chk.sv
module hcvt_lane0_chk #(
  parameter int VEC_W = 512
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [127:32]    src_hi,
  input logic [31:0]      old_lane0,
  input logic             pred_bit,
  input logic             pred_en,
  input logic             zero_mode,
  input logic             quiet_exc,
  input logic             out_valid,
  input logic [VEC_W-1:0] dst,
  input logic             flag_invalid,
  input logic             flag_denorm
);

  generate
    if (VEC_W > 128) begin : g_upper
      assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dst[VEC_W-1:128] == '0);
    end
  endgenerate

  assert_passthrough_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> dst[127:32] == $past(src_hi));

  assert_zeroing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pred_en && !pred_bit && zero_mode) |=> dst[31:0] == 32'h0);

  assert_merging_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pred_en && !pred_bit && !zero_mode) |=> dst[31:0] == $past(old_lane0));

  assert_suppress_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && quiet_exc) |=> (!flag_invalid && !flag_denorm));

  assert_masked_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pred_en && !pred_bit) |=> (!flag_invalid && !flag_denorm));

  assert_flag_with_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!flag_invalid && !flag_denorm));

  assert_valid_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(dst)));

endmodule

bind hcvt_lane0_unit hcvt_lane0_chk #(.VEC_W(VEC_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .src_hi       (src_a[127:32]),
  .old_lane0    (old_lane0),
  .pred_bit     (pred_bit),
  .pred_en      (pred_en),
  .zero_mode    (zero_mode),
  .quiet_exc    (quiet_exc),
  .out_valid    (out_valid),
  .dst          (dst),
  .flag_invalid (flag_invalid),
  .flag_denorm  (flag_denorm)
);

// File: tb/hcvt_lane0_unit_tb_top.sv
module hcvt_lane0_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int VEC_W      = 512;
  localparam int WATCHDOG   = 50000;

  typedef struct packed {
    logic [VEC_W-1:0] dst;
    logic             inv;
    logic             den;
    logic [7:0]       req;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid;
  logic [127:0]     src_a;
  logic [15:0]      src_b;
  logic [31:0]      old_lane0;
  logic             pred_bit, pred_en, zero_mode, quiet_exc;
  logic             out_valid;
  logic [VEC_W-1:0] dst;
  logic             flag_invalid, flag_denorm;

  int   total = 0;
  int   bad   = 0;
  int   cyc   = 0;
  bit   done  = 1'b0;
  exp_t exp_q[$];
  logic [VEC_W-1:0] last_dst;

  always #(CLK_PERIOD/2) clk = ~clk;

  hcvt_lane0_unit #(.VEC_W(VEC_W)) dut_i (
    .clk, .rst_n, .in_valid, .src_a, .src_b, .old_lane0,
    .pred_bit, .pred_en, .zero_mode, .quiet_exc,
    .out_valid, .dst, .flag_invalid, .flag_denorm
  );

  // Reference widening built from R1..R4 by stepwise normalization.
  function automatic logic [31:0] ref_widen(input logic [15:0] h);
    logic       s;
    logic [4:0] e;
    logic [9:0] f;
    logic [10:0] m;
    int         ex;
    s = h[15]; e = h[14:10]; f = h[9:0];
    if (e == 5'd31) begin
      if (f == 0) return {s, 8'hFF, 23'h0};
      return {s, 8'hFF, 1'b1, f[8:0], 13'h0};
    end
    if (e == 5'd0) begin
      if (f == 0) return {s, 31'h0};
      m = {1'b0, f};
      ex = -14;
      while (!m[10]) begin
        m = m << 1;
        ex = ex - 1;
      end
      return {s, 8'(ex + 127), m[9:0], 13'h0};
    end
    return {s, 8'(int'(e) - 15 + 127), f, 13'h0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [VEC_W-1:0] act,
                     input logic [VEC_W-1:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Driver: presents one request for one cycle and queues its expectation.
  task automatic send(input logic [127:0] a, input logic [15:0] b, input logic [31:0] old,
                      input logic pen, input logic pb, input logic zm, input logic qx,
                      input logic [7:0] req);
    exp_t  x;
    logic  live;
    logic [31:0] lane;
    live = !pen || pb;
    lane = live ? ref_widen(b) : (zm ? 32'h0 : old);
    x.dst = '0;
    x.dst[127:32] = a[127:32];
    x.dst[31:0]   = lane;
    x.inv = live && !qx && (b[14:10] == 5'd31) && !b[9] && (b[8:0] != 0);
    x.den = live && !qx && (b[14:10] == 5'd0) && (b[9:0] != 0);
    x.req = req;
    last_dst = x.dst;
    exp_q.push_back(x);
    in_valid = 1'b1; src_a = a; src_b = b; old_lane0 = old;
    pred_en = pen; pred_bit = pb; zero_mode = zm; quiet_exc = qx;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // Monitor: pops and compares on every produced result (R11, R12).
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R12 unexpected result", {509'h0, out_valid, flag_invalid, flag_denorm}, '0);
        end else begin
          exp_t x;
          x = exp_q.pop_front();
          chk(dst == x.dst, $sformatf("R%0d dst", x.req), dst, x.dst);
          chk({flag_invalid, flag_denorm} == {x.inv, x.den}, $sformatf("R%0d flags", x.req),
              VEC_W'({flag_invalid, flag_denorm}), VEC_W'({x.inv, x.den}));
        end
      end else if (flag_invalid || flag_denorm) begin
        chk(1'b0, "R11 flag without valid", VEC_W'({flag_invalid, flag_denorm}), '0);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [127:0] A1 = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; src_a = '0; src_b = '0; old_lane0 = '0;
    pred_bit = 1'b0; pred_en = 1'b0; zero_mode = 1'b0; quiet_exc = 1'b0;
    repeat (3) @(negedge clk);
    // R13: reset state
    chk(dst == '0 && !out_valid && !flag_invalid && !flag_denorm, "R13 reset",
        dst, '0);
    rst_n = 1'b1;
    @(negedge clk);

    send(A1, 16'h3C00, 32'hAAAA_AAAA, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1); // R1 1.0, R7 pred off
    send(A1, 16'hC000, 32'h0,         1'b1, 1'b1, 1'b0, 1'b0, 8'd1); // R1 -2.0, R7 bit set
    send(A1, 16'h7BFF, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 8'd1); // R1 largest normal
    send(A1, 16'h0400, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 8'd1); // R1 smallest normal
    send(A1, 16'h0000, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 8'd2); // R2 +0
    send(A1, 16'h8000, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 8'd2); // R2 -0
    send(A1, 16'h7C00, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 8'd2); // R2 +inf
    send(A1, 16'hFC00, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 8'd2); // R2 -inf
    idle(2);
    send(A1, 16'h0001, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 8'd3); // R3 smallest subnormal
    send(A1, 16'h83FF, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 8'd3); // R3 largest subnormal
    send(A1, 16'h0155, 32'h0,         1'b1, 1'b1, 1'b0, 1'b0, 8'd3); // R3 mid subnormal
    send(A1, 16'h7C01, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 8'd4); // R4 sNaN
    send(A1, 16'hFDAB, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 8'd4); // R4 sNaN payload
    send(A1, 16'h7E00, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 8'd4); // R4 qNaN, no invalid
    idle(1);
    send(~A1, 16'h7C01, 32'h1234_5678, 1'b1, 1'b0, 1'b1, 1'b0, 8'd8);  // R8 zeroing, R11 masked sNaN
    send(~A1, 16'h0001, 32'h1234_5678, 1'b1, 1'b0, 1'b0, 1'b0, 8'd9);  // R9 merging, R11 masked subnormal
    send(A1,  16'h3C00, 32'hDEAD_BEEF, 1'b1, 1'b0, 1'b0, 1'b0, 8'd5);  // R5 passthrough when masked
    send(A1,  16'h7C01, 32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 8'd10); // R10 suppress invalid
    send(A1,  16'h0200, 32'h0,         1'b1, 1'b1, 1'b1, 1'b1, 8'd10); // R10 suppress denormal
    idle(4);
    // R12: destination holds while idle
    chk(dst == last_dst && !out_valid, "R12 hold", dst, last_dst);

    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      r = $urandom;
      send(rnd128(), 16'($urandom), $urandom, r[0], r[1], r[2], r[3] & r[4], 8'd6); // R6 upper zero
      if (r[7:5] == 3'd0) idle(int'(r[9:8]) + 1);
    end
    idle(3);

    // R13: reset in mid-run clears registered state
    rst_n = 1'b0;
    #1;
    chk(dst == '0 && !out_valid && !flag_invalid && !flag_denorm, "R13 async clear", dst, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    send(A1, 16'h0001, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd3); // R3 after reset
    idle(3);

    chk(exp_q.size() == 0, "R12 all results seen", VEC_W'(exp_q.size()), '0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule